// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the frame (left/right) clock for the serial port of an audio converter. Both are derived from the master clock it runs on. A 3-bit mode code picks one of three kinds of operation. In slave operation the block drives nothing and flags that the serial clocks come from outside. In master operation it generates the clocks at one of four master-clock-to-sample-rate ratios. The remaining codes are reserved and leave the block silent. The ratios include two that are not powers of two, so the bit-clock divider must divide by 6 and by 12 while keeping an exact 50% duty cycle.

An active-low power-down input holds every divider in reset and forces the clock outputs low. The mode code is captured only while power-down is asserted, so a running configuration never changes under its own clocks. Leaving power-down starts the dividers from a fixed phase. The first frame edge therefore always lands a known number of bit clocks after release. Two indicators serve the board around the block: one tells whether a master code is held, for steering external tri-state buffers, and one tells whether the held code is reserved.

Top module: `audio_clkgen`

## Requirements
- R1: Mode code decode: 0 = slave; 2, 3, 6, 7 = master with bit-clock half periods of 2, 4, 3 and 6 master-clock cycles (256, 512, 384 and 768 times the sample rate); 1, 4, 5 = reserved. `is_master` is 1 exactly when the held code is a master code.
- R2: With a reserved code held, `mode_rsvd` is 1, and `bclk_o`, `frm_o` and `clk_oe` stay 0.
- R3: In master operation `bclk_o` is a square wave whose high and low phases each last exactly the half period of R1, so the bit clock runs at 64 times the sample rate.
- R4: `frm_o` holds each level for exactly 32 bit-clock periods, so one frame period is 64 bit clocks.
- R5: `frm_o` changes only on the same master-clock edge on which `bclk_o` falls.
- R6: While `pd_n` is 0 the block is idle. At the edge that samples `pd_n` low, `clk_oe` and `ext_clk` go to 0. From the following edge on, `bclk_o` and `frm_o` are 0.
- R7: The mode code is copied from `mode_sel` on every edge at which `pd_n` is 0 and is frozen while `pd_n` is 1. Reset clears the held code to 0 (slave).
- R8: Counting from the edge that first samples `pd_n` high (edge 0) with a master code held, `bclk_o` first rises at edge H and `frm_o` first rises at edge 64·H, where H is the half period of R1.
- R9: With the slave code held and `pd_n` high, `ext_clk` is 1 and `bclk_o`, `frm_o`, `clk_oe` and `is_master` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; also opens the mode capture |
| mode_sel | input | 3 | Requested mode code |
| bclk_o | output | 1 | Generated bit clock (master operation) |
| frm_o | output | 1 | Generated frame clock (master operation) |
| clk_oe | output | 1 | Output enable for `bclk_o` and `frm_o` |
| is_master | output | 1 | Held code is a master code |
| ext_clk | output | 1 | Slave operation active: serial clocks come from outside |
| mode_rsvd | output | 1 | Held code is reserved |

## Verification
The hardest situation to reach from the ports is a request to change the mode while the clocks are running. The block must ignore it, and that can only be seen by showing that the waveform keeps its old timing over whole frames. The bench starts the 256-ratio mode, then moves `mode_sel` to a different master code and then to a reserved code mid-run. It compares every master-clock cycle against a closed-form timing model of the original ratio. A second hard case is the 768-ratio mode, whose frame edge lies 384 cycles after release. The bench reaches it by running that mode for two full frames and checking each cycle against the same model.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    MK_SLAVE  = 2'd0,
    MK_MASTER = 2'd1,
    MK_RSVD   = 2'd2
  } mode_kind_e;

  // Classify a mode code.
  function automatic mode_kind_e kind_of(input logic [MODE_W-1:0] code);
    mode_kind_e k;
    case (code)
      3'd0:                      k = MK_SLAVE;
      3'd2, 3'd3, 3'd6, 3'd7:    k = MK_MASTER;
      default:                   k = MK_RSVD;
    endcase
    return k;
  endfunction

  // Bit-clock half period in master-clock cycles (ratio / 128).
  function automatic int unsigned half_of(input logic [MODE_W-1:0] code);
    int unsigned h;
    case (code)
      3'd2:    h = 2;   // 256x
      3'd3:    h = 4;   // 512x
      3'd6:    h = 3;   // 384x
      3'd7:    h = 6;   // 768x
      default: h = 0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/audio_clkgen_modectl.sv
module audio_clkgen_modectl #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [MODE_W-1:0] mode_sel,
  output logic              pd_q,
  output logic [MODE_W-1:0] mode_q
);

  // The code is sampled only while powered down, so a running setup is frozen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      pd_q <= pd_n;
      if (!pd_n) mode_q <= mode_sel;
    end
  end

endmodule

// File: rtl/audio_clkgen_bdiv.sv
module audio_clkgen_bdiv #(
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half_i,
  output logic          bclk_q,
  output logic          rise_evt,
  output logic          fall_evt
);

  logic [HW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = run && (cnt_q == half_i - HW'(1));
  assign rise_evt = wrap && !bclk_q;
  assign fall_evt = wrap &&  bclk_q;

  // Even divide by 2*half: equal high and low phases for any half value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + HW'(1);
    end
  end

endmodule

// File: rtl/audio_clkgen_fdiv.sv
module audio_clkgen_fdiv #(
  parameter int SLOT_BCLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fall_evt,
  output logic frm_q
);

  localparam int SW = (SLOT_BCLKS > 1) ? $clog2(SLOT_BCLKS) : 1;

  logic [SW-1:0] slot_q;
  logic          slot_end;

  assign slot_end = (slot_q == SW'(SLOT_BCLKS - 1));

  // Frame clock moves only together with a bit-clock falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      frm_q  <= 1'b0;
    end else if (!run) begin
      slot_q <= '0;
      frm_q  <= 1'b0;
    end else if (fall_evt) begin
      if (slot_end) begin
        slot_q <= '0;
        frm_q  <= ~frm_q;
      end else begin
        slot_q <= slot_q + SW'(1);
      end
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int MAX_HALF   = 6,
  parameter int SLOT_BCLKS = 32
) (
  input  logic       mclk_i,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic [2:0] mode_sel,
  output logic       bclk_o,
  output logic       frm_o,
  output logic       clk_oe,
  output logic       is_master,
  output logic       ext_clk,
  output logic       mode_rsvd
);

  import audio_clkgen_pkg::*;

  localparam int HW = $clog2(MAX_HALF + 1);

  logic              pd_q;
  logic [MODE_W-1:0] mode_q;
  mode_kind_e        kind_w;
  logic [HW-1:0]     half_w;
  logic              run_w;
  logic              bclk_rise_w;
  logic              bclk_fall_w;

  audio_clkgen_modectl #(.MODE_W(MODE_W)) u_modectl (
    .clk      (mclk_i),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .mode_sel (mode_sel),
    .pd_q     (pd_q),
    .mode_q   (mode_q)
  );

  assign kind_w = kind_of(mode_q);
  assign half_w = HW'(half_of(mode_q));
  assign run_w  = pd_q && (kind_w == MK_MASTER);

  audio_clkgen_bdiv #(.HW(HW)) u_bdiv (
    .clk      (mclk_i),
    .rst_n    (rst_n),
    .run      (run_w),
    .half_i   (half_w),
    .bclk_q   (bclk_o),
    .rise_evt (bclk_rise_w),
    .fall_evt (bclk_fall_w)
  );

  audio_clkgen_fdiv #(.SLOT_BCLKS(SLOT_BCLKS)) u_fdiv (
    .clk      (mclk_i),
    .rst_n    (rst_n),
    .run      (run_w),
    .fall_evt (bclk_fall_w),
    .frm_q    (frm_o)
  );

  assign clk_oe    = run_w;
  assign is_master = (kind_w == MK_MASTER);
  assign ext_clk   = pd_q && (kind_w == MK_SLAVE);
  assign mode_rsvd = (kind_w == MK_RSVD);

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int HW         = 3,
  parameter int SLOT_BCLKS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pd_q,
  input logic          run,
  input logic [2:0]    mode_q,
  input logic [HW-1:0] half,
  input logic          bclk_o,
  input logic          frm_o,
  input logic          clk_oe,
  input logic          is_master,
  input logic          ext_clk,
  input logic          mode_rsvd
);

  logic       bclk_prev, frm_prev, seen_edge;
  logic [7:0] stay_c;
  logic [7:0] fall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev <= 1'b0;
      frm_prev  <= 1'b0;
      seen_edge <= 1'b0;
      stay_c    <= 8'd1;
      fall_c    <= 8'd0;
    end else begin
      bclk_prev <= bclk_o;
      frm_prev  <= frm_o;
      if (!run) begin
        seen_edge <= 1'b0;
        stay_c    <= 8'd1;
        fall_c    <= 8'd0;
      end else begin
        if (bclk_o != bclk_prev) begin
          stay_c    <= 8'd1;
          seen_edge <= 1'b1;
        end else if (stay_c != 8'hff) begin
          stay_c    <= stay_c + 8'd1;
        end
        if (frm_o != frm_prev)              fall_c <= 8'd0;
        else if (bclk_prev && !bclk_o)      fall_c <= fall_c + 8'd1;
      end
    end
  end

  // R3: each bit-clock phase lasts exactly the selected half period
  p_bclk_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && seen_edge && (bclk_o != bclk_prev)) |-> (stay_c == 8'(half)));

  // R4: 32 bit-clock falls per frame level
  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (frm_o != frm_prev)) |-> (fall_c + 8'd1 == 8'(SLOT_BCLKS)));

  // R5: frame moves only with a bit-clock fall
  p_frm_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(frm_o)) |-> $fell(bclk_o));

  // R2: a reserved code held over an edge keeps every clock low
  p_rsvd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rsvd && $past(mode_rsvd)) |-> (!clk_oe && !bclk_o && !frm_o));

  // R6: power-down drops enables now and clocks one edge later
  p_pd_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_q |-> (!clk_oe && !ext_clk));
  p_pd_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_q |=> (!bclk_o && !frm_o));

  // R7: held code is frozen while powered up
  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && $past(pd_q)) |-> $stable(mode_q));

  // R1: output enable only with a master code
  p_oe_master_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_oe |-> is_master);

  // R9: slave indication excludes driven clocks
  p_slave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk |-> (!clk_oe && !is_master && !mode_rsvd));

endmodule

bind audio_clkgen audio_clkgen_chk #(.HW(HW), .SLOT_BCLKS(SLOT_BCLKS)) u_chk (
  .clk       (mclk_i),
  .rst_n     (rst_n),
  .pd_q      (pd_q),
  .run       (run_w),
  .mode_q    (mode_q),
  .half      (half_w),
  .bclk_o    (bclk_o),
  .frm_o     (frm_o),
  .clk_oe    (clk_oe),
  .is_master (is_master),
  .ext_clk   (ext_clk),
  .mode_rsvd (mode_rsvd)
);

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/1ps
module audio_clkgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       bclk_o, frm_o, clk_oe, is_master, ext_clk, mode_rsvd;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  audio_clkgen u_audio_clkgen (
    .mclk_i    (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .mode_sel  (mode_sel),
    .bclk_o    (bclk_o),
    .frm_o     (frm_o),
    .clk_oe    (clk_oe),
    .is_master (is_master),
    .ext_clk   (ext_clk),
    .mode_rsvd (mode_rsvd)
  );

  task automatic expect_bit(input string req, input string what,
                            input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Bench's own table of the mode meanings.
  function automatic int exp_half(input logic [2:0] c);
    if (c == 3'd2) return 2;
    if (c == 3'd3) return 4;
    if (c == 3'd6) return 3;
    if (c == 3'd7) return 6;
    return 0;
  endfunction

  // Hold power-down with a code, then release; returns just after edge 0.
  task automatic enter_mode(input logic [2:0] code);
    @(negedge clk);
    pd_n = 1'b0;
    mode_sel = code;
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    expect_bit("R7", "reset clk_oe", clk_oe, 1'b0);
    expect_bit("R7", "reset is_master (slave held)", is_master, 1'b0);
    expect_bit("R7", "reset bclk", bclk_o, 1'b0);
    expect_bit("R7", "reset frm", frm_o, 1'b0);
    expect_bit("R2", "reset mode_rsvd", mode_rsvd, 1'b0);
  endtask

  // Per-cycle compare against bclk = (k/H)%2, frm = (k/(64H))%2 (R1 R3 R4 R5 R8).
  task automatic t_master(input logic [2:0] code, input bit poke_mode);
    int h, bad0;
    h = exp_half(code);
    enter_mode(code);
    expect_bit("R1", "is_master", is_master, 1'b1);
    expect_bit("R1", "clk_oe after release", clk_oe, 1'b1);
    expect_bit("R1", "mode_rsvd", mode_rsvd, 1'b0);
    expect_bit("R8", "bclk at edge 0", bclk_o, 1'b0);
    for (int k = 1; k <= 2 * 128 * h + 8; k++) begin
      @(posedge clk);
      #1;
      if (poke_mode && k == 10) mode_sel = 3'd7;
      if (poke_mode && k == 40) mode_sel = 3'd1;
      bad0 = n_bad;
      expect_bit((k == h) ? "R8" : "R3", "bclk", bclk_o, 1'(((k / h) % 2) == 1));
      expect_bit((k == 64 * h) ? "R8" : "R4", "frm", frm_o, 1'(((k / (64 * h)) % 2) == 1));
      if (poke_mode) expect_bit("R7", "clk_oe kept", clk_oe, 1'b1);
      if (n_bad != bad0) break;
    end
  endtask

  task automatic t_reserved(input logic [2:0] code);
    enter_mode(code);
    expect_bit("R2", "mode_rsvd", mode_rsvd, 1'b1);
    expect_bit("R1", "is_master", is_master, 1'b0);
    for (int k = 0; k < 200; k++) begin
      @(posedge clk);
      #1;
      if (bclk_o !== 1'b0 || frm_o !== 1'b0 || clk_oe !== 1'b0 || k == 199) begin
        expect_bit("R2", "bclk", bclk_o, 1'b0);
        expect_bit("R2", "frm", frm_o, 1'b0);
        expect_bit("R2", "clk_oe", clk_oe, 1'b0);
        break;
      end
    end
  endtask

  task automatic t_slave;
    enter_mode(3'd0);
    repeat (20) @(posedge clk);
    #1;
    expect_bit("R9", "ext_clk", ext_clk, 1'b1);
    expect_bit("R9", "clk_oe", clk_oe, 1'b0);
    expect_bit("R9", "is_master", is_master, 1'b0);
    expect_bit("R9", "bclk", bclk_o, 1'b0);
    expect_bit("R9", "frm", frm_o, 1'b0);
  endtask

  // Power-down in the middle of a frame-high phase (H=3: frame high from edge 192).
  task automatic t_powerdown;
    enter_mode(3'd6);
    repeat (200) @(posedge clk);
    #1;
    expect_bit("R4", "frm high before power-down", frm_o, 1'b1);
    @(negedge clk);
    pd_n = 1'b0;
    @(posedge clk);
    #1;
    expect_bit("R6", "clk_oe at sampling edge", clk_oe, 1'b0);
    expect_bit("R6", "is_master kept", is_master, 1'b1);
    @(posedge clk);
    #1;
    expect_bit("R6", "bclk idle", bclk_o, 1'b0);
    expect_bit("R6", "frm idle", frm_o, 1'b0);
    repeat (30) @(posedge clk);
    #1;
    expect_bit("R6", "bclk still idle", bclk_o, 1'b0);
  endtask

  // Reset while running with pd_n high: held code returns to slave.
  task automatic t_reset_slave;
    enter_mode(3'd3);
    repeat (50) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_bit("R7", "async reset bclk", bclk_o, 1'b0);
    expect_bit("R7", "async reset clk_oe", clk_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_bit("R7", "slave after reset", ext_clk, 1'b1);
    expect_bit("R9", "no master after reset", is_master, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_master(3'd2, 1'b0);
    t_master(3'd3, 1'b0);
    t_master(3'd6, 1'b0);
    t_master(3'd7, 1'b0);
    t_reserved(3'd1);
    t_reserved(3'd4);
    t_reserved(3'd5);
    t_slave();
    t_master(3'd2, 1'b1);
    t_powerdown();
    t_reset_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule